// File: doc/BRIEF.md
# Bidirectional Cascadable Column Data Loader

This block collects one display line of colour data for a 240-channel column driver. Each clock delivers an 18-bit word that carries three 6-bit subpixel values. A start pulse sets up a single enable token. The token then steps through 80 address stages. At each stage the word held in an input latch is copied into three neighbouring channels of a 240 x 6 line register. A direction input sets two things: the order in which channels fill, and which of the two cascade pins acts as the start input and which as the cascade output.

Several of these loaders can be chained so that a wide panel line is split across drivers. The token leaves one loader on its cascade output one clock before the loader finishes. The next loader in the chain sees that pulse as its own start pulse on the edge where the first loader performs its last write, so the incoming word stream never stalls. A loader with no token is idle. It raises a standby flag until its next start pulse.

Top module: `cdl_column_loader`

## Requirements
- R1: After reset, standby_o is 1, both cascade outputs are 0, and the line register holds its contents until a start pulse arrives.
- R2: On the rising edge where the active start input is high (edge 0), the word is captured into the latch, no channel changes, and standby_o drops to 0 after that edge.
- R3: With dir_r=1, rising edge n (n = 1..80) writes the latched word to channels 3n-2, 3n-1 and 3n (1-based) in ascending order. The word present at edge k (k = 0..79) ends up in triple k+1. After edge 80 all 240 channels hold the new line.
- R4: In ascending mode, word bits [5:0] go to channel 3n-2, bits [11:6] to channel 3n-1 and bits [17:12] to channel 3n. Channel c is read at line_q[6(c-1)+5 : 6(c-1)].
- R5: With dir_r=0, edge n writes channels 241-3n, 242-3n and 243-3n. Bits [5:0] go to 243-3n, bits [11:6] to 242-3n and bits [17:12] to 241-3n.
- R6: With dir_r=1, casc_a is the start input, casc_b_oe=1 and casc_a_oe=0. With dir_r=0 these roles are swapped. The output of the pin in the input role is held at 0.
- R7: The cascade output in the output role is 1 for exactly the clock between edges 79 and 80, and 0 at all other times.
- R8: standby_o rises after edge 80 and stays 1 until the next start pulse. While standby_o is 1, data input changes leave every channel unchanged.
- R9: A pulse on the cascade input of the pin in the output role has no effect: standby_o stays 1, no channel changes and the cascade outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dir_r | input | 1 | 1 = ascending fill (casc_a is the start input), 0 = descending fill |
| casc_a_i | input | 1 | Cascade pin A, input side |
| casc_a_o | output | 1 | Cascade pin A, output side |
| casc_a_oe | output | 1 | Cascade pin A, output enable |
| casc_b_i | input | 1 | Cascade pin B, input side |
| casc_b_o | output | 1 | Cascade pin B, output side |
| casc_b_oe | output | 1 | Cascade pin B, output enable |
| pix_i | input | 18 | Three 6-bit subpixel values for one channel triple |
| line_q | output | 1440 | Line register, channel c at bits [6c-1 : 6c-6] |
| standby_o | output | 1 | 1 while no token is inside the loader |

## Verification
A token that is lost, duplicated or shifted by one stage shows up at the next full-line comparison as channels holding another triple's word. It also moves the cascade pulse away from the clock between edges 79 and 80, so the fault is visible within one line time. A lane or mirroring fault puts a value into the wrong neighbour within a triple. The bench uses a different value in each lane and each word to expose this. A spurious write while idle alters the stored line within a cycle, and the bench checks for it with the data changing.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  localparam int unsigned CDL_STAGES = 80;
  localparam int unsigned CDL_LANES  = 3;
  localparam int unsigned CDL_SUB_W  = 6;
endpackage

// File: rtl/cdl_word_latch.sv
module cdl_word_latch #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (en_i) word_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign q_o = word_q;
endmodule

// File: rtl/cdl_token_walk.sv
module cdl_token_walk #(
  parameter int unsigned STAGES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [STAGES-1:0] tok_o,
  output logic              exit_o,
  output logic              load_o,
  output logic              standby_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] tok_q, tok_d;
  logic              stby_q, stby_d;

  always_comb begin
    tok_d  = {tok_q[STAGES-2:0], 1'b0};
    stby_d = stby_q;
    if (tok_q[LAST]) stby_d = 1'b1;
    if (start_i) begin
      tok_d  = {{(STAGES-1){1'b0}}, 1'b1};
      stby_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q  <= '0;
      stby_q <= 1'b1;
    end else begin
      tok_q  <= tok_d;
      stby_q <= stby_d;
    end
  end

  assign tok_o     = tok_q;
  assign exit_o    = tok_q[LAST];
  assign load_o    = start_i | (|tok_q);
  assign standby_o = stby_q;
endmodule

// File: rtl/cdl_line_store.sv
module cdl_line_store #(
  parameter int unsigned STAGES = 80,
  parameter int unsigned LANES  = 3,
  parameter int unsigned SUB_W  = 6
) (
  input  logic                            clk,
  input  logic                            asc_i,
  input  logic [STAGES-1:0]               tok_i,
  input  logic [LANES*SUB_W-1:0]          word_i,
  output logic [STAGES*LANES*SUB_W-1:0]   line_o
);
  localparam int unsigned CHANS = STAGES * LANES;

  for (genvar k = 0; k < CHANS; k++) begin : g_chan
    localparam int unsigned TA = k / LANES;
    localparam int unsigned LA = k % LANES;
    localparam int unsigned TD = STAGES - 1 - (k / LANES);
    localparam int unsigned LD = LANES - 1 - (k % LANES);

    logic [SUB_W-1:0] cell_q;
    logic [SUB_W-1:0] cell_sel;
    logic             cell_we;

    always_comb begin
      cell_we  = asc_i ? tok_i[TA] : tok_i[TD];
      cell_sel = asc_i ? word_i[LA*SUB_W +: SUB_W] : word_i[LD*SUB_W +: SUB_W];
    end

    always_ff @(posedge clk) begin
      if (cell_we) cell_q <= cell_sel;
    end

    assign line_o[k*SUB_W +: SUB_W] = cell_q;
  end
endmodule

// File: rtl/cdl_column_loader.sv
module cdl_column_loader
  import cdl_pkg::*;
#(
  parameter int unsigned STAGES = CDL_STAGES,
  parameter int unsigned LANES  = CDL_LANES,
  parameter int unsigned SUB_W  = CDL_SUB_W,
  localparam int unsigned WORD_W = LANES * SUB_W,
  localparam int unsigned LINE_W = STAGES * LANES * SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_r,
  input  logic              casc_a_i,
  output logic              casc_a_o,
  output logic              casc_a_oe,
  input  logic              casc_b_i,
  output logic              casc_b_o,
  output logic              casc_b_oe,
  input  logic [WORD_W-1:0] pix_i,
  output logic [LINE_W-1:0] line_q,
  output logic              standby_o
);
  logic              start_act;
  logic [STAGES-1:0] tok_q;
  logic              tok_exit;
  logic              latch_en;
  logic [WORD_W-1:0] word_q;

  assign start_act = dir_r ? casc_a_i : casc_b_i;

  cdl_token_walk #(.STAGES(STAGES)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_act),
    .tok_o     (tok_q),
    .exit_o    (tok_exit),
    .load_o    (latch_en),
    .standby_o (standby_o)
  );

  cdl_word_latch #(.WORD_W(WORD_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (latch_en),
    .d_i   (pix_i),
    .q_o   (word_q)
  );

  cdl_line_store #(.STAGES(STAGES), .LANES(LANES), .SUB_W(SUB_W)) u_store (
    .clk    (clk),
    .asc_i  (dir_r),
    .tok_i  (tok_q),
    .word_i (word_q),
    .line_o (line_q)
  );

  assign casc_b_oe = dir_r;
  assign casc_a_oe = ~dir_r;
  assign casc_b_o  = dir_r & tok_exit;
  assign casc_a_o  = ~dir_r & tok_exit;
endmodule

// File: rtl/cdl_column_loader_chk.sv
module cdl_column_loader_chk #(
  parameter int unsigned STAGES = 80,
  parameter int unsigned LINE_W = 1440
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_act,
  input logic [STAGES-1:0] tok_q,
  input logic              casc_a_o,
  input logic              casc_a_oe,
  input logic              casc_b_o,
  input logic              casc_b_oe,
  input logic              standby_o,
  input logic [LINE_W-1:0] line_q
);
  // R3
  token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q));

  // R6
  pin_roles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({casc_a_oe, casc_b_oe}));

  // R6
  idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_a_oe |-> !casc_a_o) and (!casc_b_oe |-> !casc_b_o));

  // R7
  casc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_a_o | casc_b_o) |=> !(casc_a_o | casc_b_o));

  // R8
  standby_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_o) |-> $past(tok_q[STAGES-1]));

  // R2
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_act |=> !standby_o);

  // R8
  standby_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> (tok_q == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_q == '0) |=> $stable(line_q));
endmodule

bind cdl_column_loader cdl_column_loader_chk #(.STAGES(STAGES), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_act (start_act),
  .tok_q     (tok_q),
  .casc_a_o  (casc_a_o),
  .casc_a_oe (casc_a_oe),
  .casc_b_o  (casc_b_o),
  .casc_b_oe (casc_b_oe),
  .standby_o (standby_o),
  .line_q    (line_q)
);

// File: tb/tb_cdl_column_loader.sv
module tb_cdl_column_loader;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          dir_r;
  logic          casc_a_i, casc_b_i;
  logic          casc_a_o, casc_a_oe, casc_b_o, casc_b_oe;
  logic [17:0]   pix_i;
  logic [1439:0] line_q;
  logic          standby_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [5:0] exp_m [1:240];

  always #10 clk = ~clk;

  cdl_column_loader dut (
    .clk(clk), .rst_n(rst_n), .dir_r(dir_r),
    .casc_a_i(casc_a_i), .casc_a_o(casc_a_o), .casc_a_oe(casc_a_oe),
    .casc_b_i(casc_b_i), .casc_b_o(casc_b_o), .casc_b_oe(casc_b_oe),
    .pix_i(pix_i), .line_q(line_q), .standby_o(standby_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [17:0] word(input int k, input int s);
    return {6'(k*7 + s*3 + 2), 6'(k*5 + s + 1), 6'(k*3 + s)};
  endfunction

  function automatic logic [5:0] chan(input int c);
    return line_q[(c-1)*6 +: 6];
  endfunction

  task automatic cmp_all(input string req);
    for (int c = 1; c <= 240; c++)
      chk(chan(c) === exp_m[c], req, int'(chan(c)), int'(exp_m[c]));
  endtask

  task automatic snap();
    for (int c = 1; c <= 240; c++) exp_m[c] = chan(c);
  endtask

  // write triple n (1-based) as the requirement formulas give it
  task automatic model_write(input int n, input bit asc, input logic [17:0] w);
    for (int l = 0; l < 3; l++) begin
      int c;
      c = asc ? (3*n - 2 + l) : (243 - 3*n - l);
      exp_m[c] = w[l*6 +: 6];
    end
  endtask

  task automatic set_start(input bit asc, input bit v);
    casc_a_i = asc ? v : 1'b0;
    casc_b_i = asc ? 1'b0 : v;
  endtask

  task automatic run_line(input bit asc, input int s);
    string rq;
    rq = asc ? "R3/R4" : "R5";
    dir_r = asc;
    for (int k = 0; k <= 80; k++) begin
      @(negedge clk);
      if (k > 0) begin
        int e;
        logic act_o, oth_o;
        e = k - 1;
        act_o = asc ? casc_b_o : casc_a_o;
        oth_o = asc ? casc_a_o : casc_b_o;
        if (e == 0) begin
          chk(standby_o == 1'b0, "R2 standby clears", int'(standby_o), 0);
          cmp_all("R2 no write at start edge");
        end else begin
          model_write(e, asc, word(e-1, s));
        end
        if (e == 40) cmp_all({rq, " partial line order"});
        if (e == 78) chk(act_o == 1'b0, "R7 cascade early", int'(act_o), 0);
        if (e == 79) begin
          chk(act_o == 1'b1, "R7 cascade pulse", int'(act_o), 1);
          chk(oth_o == 1'b0, "R6 input-role pin low", int'(oth_o), 0);
        end
      end
      set_start(asc, k == 0);
      pix_i = (k <= 79) ? word(k, s) : ~word(k, s);
    end
    @(negedge clk);
    model_write(80, asc, word(79, s));
    chk(casc_a_o == 1'b0 && casc_b_o == 1'b0, "R7 cascade ends",
        int'({casc_a_o, casc_b_o}), 0);
    chk(standby_o == 1'b1, "R8 standby after exit", int'(standby_o), 1);
    cmp_all({rq, " full line"});
  endtask

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_r = 1'b1; casc_a_i = 1'b0; casc_b_i = 1'b0; pix_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(standby_o == 1'b1, "R1 standby", int'(standby_o), 1);
    chk(casc_a_o == 1'b0 && casc_b_o == 1'b0, "R1 cascade low",
        int'({casc_a_o, casc_b_o}), 0);
    snap();
    for (int i = 0; i < 5; i++) begin
      pix_i = word(i, 33);
      @(negedge clk);
    end
    cmp_all("R1 hold before start");
    // R6 pin roles
    chk(casc_b_oe == 1'b1 && casc_a_oe == 1'b0, "R6 roles asc",
        int'({casc_a_oe, casc_b_oe}), 1);
    dir_r = 1'b0;
    @(negedge clk);
    chk(casc_a_oe == 1'b1 && casc_b_oe == 1'b0, "R6 roles desc",
        int'({casc_a_oe, casc_b_oe}), 2);

    run_line(1'b1, 1);
    run_line(1'b0, 9);
    run_line(1'b1, 20);

    // R8 idle data changes have no effect
    for (int i = 0; i < 8; i++) begin
      pix_i = word(i, 50);
      @(negedge clk);
    end
    chk(standby_o == 1'b1, "R8 standby held", int'(standby_o), 1);
    cmp_all("R8 idle hold");

    // R9 start on output-role pin ignored, both directions
    for (int d = 0; d < 2; d++) begin
      dir_r = d[0];
      casc_a_i = ~d[0];
      casc_b_i = d[0];
      pix_i = word(d, 60);
      @(negedge clk);
      casc_a_i = 1'b0; casc_b_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
        pix_i = word(i, 70 + d);
        @(negedge clk);
      end
      chk(standby_o == 1'b1, "R9 standby unchanged", int'(standby_o), 1);
      chk(casc_a_o == 1'b0 && casc_b_o == 1'b0, "R9 cascade low",
          int'({casc_a_o, casc_b_o}), 0);
      cmp_all("R9 no write");
    end

    run_line(1'b0, 41);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule